// File: doc/BRIEF.md
# Programmable YUV to RGB Converter

This block turns a stream of 8-bit luma/chroma samples into 8-bit red, green and blue. It accepts one pixel per clock with a valid flag. Each output channel is formed from a programmable weighted sum of the three inputs plus a programmable offset. The sum is then rounded and clamped to the 0..255 range. The chroma inputs enter as raw unsigned codes: the usual mid-scale offset of 128 is folded into each channel's constant. After reset the coefficients hold values for studio-range SD video (Y in 16..235, chroma in 16..240) to full-range RGB.

A bypass input marks pixels that are already RGB; these reach the outputs untouched. The valid flag travels through the same registers as the data. The output therefore arrives a fixed three clocks after the input is sampled. Coefficients are loaded through a simple write port. A written value waits in a staging copy and goes into use only on a clock edge where no pixel is being accepted, so a pixel is never computed with a mix of old and new settings.

Top module: `yuv_rgb_conv`

## Requirements
- R1: After reset, out_valid and all three colour outputs are 0 and the coefficient set holds the default values listed in R5.
- R2: Coefficient address = row*4 + term, where row 0 produces G, row 1 produces R and row 2 produces B, and term 0/1/2/3 is the Y weight, U weight, V weight and constant. A write to any address from 12 to 15 changes nothing.
- R3: Each weight is a 13-bit two's-complement value with 10 fractional bits, taken from cfg_wdata[12:0]; bit 13 is ignored for weight addresses. Each constant is a 14-bit two's-complement value with 4 fractional bits, taken from cfg_wdata[13:0].
- R4: Every output channel equals clamp(floor((wy*Y + wu*U + wv*V + k*64 + 512) / 1024)), with Y, U and V read as unsigned integers.
- R5: The default rows are G = {0x04a7, 0x1e6f, 0x1cbf, 0x0877}, R = {0x04a7, 0x0000, 0x0662, 0x3211} and B = {0x04a7, 0x0812, 0x0000, 0x2eb1}. With these values, Y=16/U=V=128 gives black and Y=235/U=V=128 gives white (255,255,255).
- R6: A rounded result below 0 comes out as 0, and one above 255 comes out as 255.
- R7: A pixel accepted with bypass=1 leaves with out_r=in_y_r, out_g=in_u_g and out_b=in_v_b, unmodified.
- R8: A pixel sampled with in_valid=1 on clock edge n appears, together with out_valid=1, right after edge n+3. out_valid is 0 in every other cycle.
- R9: A coefficient write takes effect only from the first clock edge on which in_valid is 0, counting the write edge itself. Pixels accepted in an unbroken valid run that began before that edge use the old values.
- R10: Pixels may arrive on consecutive cycles. Each one yields exactly one output, and outputs keep input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient address (row*4 + term) |
| cfg_wdata | input | 14 | Coefficient value |
| in_valid | input | 1 | Input pixel valid |
| in_bypass | input | 1 | Pixel is already RGB; skip conversion |
| in_y_r | input | 8 | Y sample, or R in bypass |
| in_u_g | input | 8 | U sample, or G in bypass |
| in_v_b | input | 8 | V sample, or B in bypass |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
Almost all internal state shows up at the outputs within three cycles of the next accepted pixel.

- A wrong entry in the active coefficient set skews only the channel of its row. Which input pattern exposes it depends on the term: the constant is visible on every pixel, while a weight is visible only on pixels where its input is non-zero.
- A stale or early swap from staging to active copy shows as a wrong value on the first pixel after an idle cycle, or on a pixel inside a run.
- A valid or bypass register that drifts out of step with the data pipeline shows as an output on the wrong cycle, or a converted pixel where a raw one was due.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int ROWS    = 3;
  localparam int TERMS   = 4;
  localparam int NCOEF   = ROWS * TERMS;
  localparam int ROW_G   = 0;
  localparam int ROW_R   = 1;
  localparam int ROW_B   = 2;
  localparam int T_CONST = 3;

  // Coefficients as stored: weights sign-extended to the constant width.
  function automatic logic [13:0] csc_default(input int idx);
    case (idx)
      0:       return 14'h04a7;
      1:       return 14'h3e6f;
      2:       return 14'h3cbf;
      3:       return 14'h0877;
      4:       return 14'h04a7;
      5:       return 14'h0000;
      6:       return 14'h0662;
      7:       return 14'h3211;
      8:       return 14'h04a7;
      9:       return 14'h0812;
      10:      return 14'h0000;
      default: return 14'h2eb1;
    endcase
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int CW = 14,
  parameter int MW = 13,
  parameter int AW = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [CW-1:0]              wdata,
  input  logic                       hold,
  output logic [NCOEF-1:0][CW-1:0]   coef
);
  logic [NCOEF-1:0][CW-1:0] stage_q, stage_nxt;

  always_comb begin
    stage_nxt = stage_q;
    for (int i = 0; i < NCOEF; i++) begin
      if (we && addr == AW'(i)) begin
        if ((i % TERMS) == T_CONST)
          stage_nxt[i] = wdata;
        else
          stage_nxt[i] = {{(CW-MW){wdata[MW-1]}}, wdata[MW-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCOEF; i++) begin
        stage_q[i] <= CW'(csc_default(i));
        coef[i]    <= CW'(csc_default(i));
      end
    end else begin
      stage_q <= stage_nxt;
      if (!hold) coef <= stage_nxt;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(coef));

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (coef[0] == CW'(14'h04a7) && coef[7] == CW'(14'h3211)
                    && coef[11] == CW'(14'h2eb1)));
endmodule

// File: rtl/csc_row.sv
module csc_row #(
  parameter int PW    = 8,
  parameter int CW    = 14,
  parameter int FRAC  = 10,
  parameter int CFRAC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PW-1:0]            a,
  input  logic [PW-1:0]            b,
  input  logic [PW-1:0]            c,
  input  logic [CW-1:0]            wa,
  input  logic [CW-1:0]            wb,
  input  logic [CW-1:0]            wc,
  input  logic [CW-1:0]            k,
  output logic signed [CW+PW+2:0]  acc,
  output logic [PW-1:0]            pix
);
  localparam int PRW  = CW + PW + 1;
  localparam int ACW  = PRW + 2;
  localparam int KSH  = FRAC - CFRAC;
  localparam int PMAX = (1 << PW) - 1;

  logic signed [PRW-1:0] pa_q, pb_q, pc_q;
  logic signed [ACW-1:0] k_q;
  logic signed [ACW-1:0] rnd;

  // Stage 1: products and aligned constant
  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
      k_q  <= '0;
    end else begin
      pa_q <= $signed(wa) * $signed({1'b0, a});
      pb_q <= $signed(wb) * $signed({1'b0, b});
      pc_q <= $signed(wc) * $signed({1'b0, c});
      k_q  <= ACW'($signed(k)) <<< KSH;
    end
  end

  // Stage 2: sum
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= ACW'(pa_q) + ACW'(pb_q) + ACW'(pc_q) + k_q;
  end

  // Round to nearest, then clamp to the pixel range
  always_comb begin
    rnd = (acc + ACW'(1 << (FRAC - 1))) >>> FRAC;
    if (rnd < 0)                    pix = '0;
    else if (rnd > ACW'(PMAX))      pix = PW'(PMAX);
    else                            pix = rnd[PW-1:0];
  end
endmodule

// File: rtl/yuv_rgb_conv.sv
module yuv_rgb_conv
  import csc_pkg::*;
#(
  parameter int PW    = 8,
  parameter int MW    = 13,
  parameter int CW    = 14,
  parameter int FRAC  = 10,
  parameter int CFRAC = 4,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          in_valid,
  input  logic          in_bypass,
  input  logic [PW-1:0] in_y_r,
  input  logic [PW-1:0] in_u_g,
  input  logic [PW-1:0] in_v_b,
  output logic          out_valid,
  output logic [PW-1:0] out_r,
  output logic [PW-1:0] out_g,
  output logic [PW-1:0] out_b
);
  localparam int DEPTH = 3;
  localparam int ACW   = CW + PW + 3;

  logic [NCOEF-1:0][CW-1:0]      coef;
  logic [DEPTH-1:0]              vld_q, byp_q;
  logic [DEPTH-1:0][2:0][PW-1:0] raw_q;
  logic [ROWS-1:0][PW-1:0]       row_pix;
  logic signed [ACW-1:0]         row_acc [ROWS];

  csc_coef_bank #(.CW(CW), .MW(MW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hold(in_valid), .coef(coef)
  );

  // Input register (stage 0) and the two tag/raw stages beside the rows
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      byp_q <= '0;
      raw_q <= '0;
    end else begin
      vld_q[0]    <= in_valid;
      byp_q[0]    <= in_bypass;
      raw_q[0][0] <= in_y_r;
      raw_q[0][1] <= in_u_g;
      raw_q[0][2] <= in_v_b;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
        byp_q[s] <= byp_q[s-1];
        raw_q[s] <= raw_q[s-1];
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    csc_row #(.PW(PW), .CW(CW), .FRAC(FRAC), .CFRAC(CFRAC)) u_row (
      .clk(clk), .rst(rst),
      .a(raw_q[0][0]), .b(raw_q[0][1]), .c(raw_q[0][2]),
      .wa(coef[r*TERMS+0]), .wb(coef[r*TERMS+1]), .wc(coef[r*TERMS+2]),
      .k(coef[r*TERMS+T_CONST]),
      .acc(row_acc[r]), .pix(row_pix[r])
    );
  end

  // Output register: converted or raw
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= vld_q[DEPTH-1];
      if (byp_q[DEPTH-1]) begin
        out_r <= raw_q[DEPTH-1][0];
        out_g <= raw_q[DEPTH-1][1];
        out_b <= raw_q[DEPTH-1][2];
      end else begin
        out_r <= row_pix[ROW_R];
        out_g <= row_pix[ROW_G];
        out_b <= row_pix[ROW_B];
      end
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst,1) && !$past(rst,2) && !$past(rst,3) && !$past(rst,4))
      |-> (out_valid == $past(in_valid, 4)));

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst,1) && !$past(rst,2) && !$past(rst,3) && !$past(rst,4)
     && $past(in_valid && in_bypass, 4))
      |-> (out_r == $past(in_y_r, 4) && out_b == $past(in_v_b, 4)));

  // R6
  clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q[DEPTH-1] && !byp_q[DEPTH-1] && row_acc[ROW_G] < 0) |=> (out_g == '0));

  // R6
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q[DEPTH-1] && !byp_q[DEPTH-1]
     && row_acc[ROW_R] >= ACW'(256 << FRAC)) |=> (out_r == '1));
endmodule

// File: tb/sim_yuv_rgb_conv.sv
module sim_yuv_rgb_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [13:0] cfg_wdata = '0;
  logic       in_valid = 1'b0, in_bypass = 1'b0;
  logic [7:0] in_y_r = '0, in_u_g = '0, in_v_b = '0;
  logic       out_valid;
  logic [7:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] r, g, b;
    string      tag;
  } exp_t;
  exp_t q[$];

  int bc [12];  // bench model of the active coefficient set

  always #4 clk = ~clk;  // 125 MHz

  yuv_rgb_conv u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_bypass(in_bypass),
    .in_y_r(in_y_r), .in_u_g(in_u_g), .in_v_b(in_v_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic int sx(input logic [13:0] d, input int w);
    int v;
    v = int'(d) & ((1 << w) - 1);
    if (v >= (1 << (w - 1))) v = v - (1 << w);
    return v;
  endfunction

  function automatic logic [7:0] chan(input int row, input int y, input int u, input int v);
    int s;
    s = bc[row*4]*y + bc[row*4+1]*u + bc[row*4+2]*v + bc[row*4+3]*64;
    s = (s + 512) >>> 10;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return 8'(s);
  endfunction

  function automatic void model_write(input int a, input logic [13:0] d);
    if (a < 12) bc[a] = ((a % 4) == 3) ? sx(d, 14) : sx(d, 13);
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Output monitor: compares every valid output with the next expected pixel
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check("R8 unexpected output", {out_r, out_g, out_b}, 24'hxxxxxx);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {out_r, out_g, out_b}, {e.r, e.g, e.b});
      end
    end
  end

  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input logic byp, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_bypass = byp;
    in_y_r = a; in_u_g = b; in_v_b = c;
    e.tag = tag;
    if (byp) begin
      e.r = a; e.g = b; e.b = c;
    end else begin
      e.r = chan(1, a, b, c); e.g = chan(0, a, b, c); e.b = chan(2, a, b, c);
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_bypass = 1'b0; cfg_we = 1'b0;
    end
  endtask

  // Write while idle: applies at once (R9), bench model follows
  task automatic wr(input int a, input logic [13:0] d);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain;
    idle(6);
    check("R10 all outputs delivered", 24'(q.size()), 24'd0);
  endtask

  task automatic load_defaults;
    logic [13:0] dv [12] = '{14'h04a7, 14'h1e6f, 14'h1cbf, 14'h0877,
                             14'h04a7, 14'h0000, 14'h0662, 14'h3211,
                             14'h04a7, 14'h0812, 14'h0000, 14'h2eb1};
    for (int i = 0; i < 12; i++) wr(i, dv[i]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset outputs", {7'd0, out_valid, out_r, out_g, out_b}, 32'd0);
  endtask

  task automatic t_defaults;
    send(8'd16, 8'd128, 8'd128, 1'b0, "R5 black");
    send(8'd235, 8'd128, 8'd128, 1'b0, "R5 white");
    idle(1);
    drain();
    check("R5 model black", {chan(1,16,128,128), chan(0,16,128,128), chan(2,16,128,128)}, 24'h000000);
    check("R5 model white", {chan(1,235,128,128), chan(0,235,128,128), chan(2,235,128,128)}, 24'hffffff);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 10; i++)
      send(8'(20 + i*21), 8'(30 + i*19), 8'(230 - i*17), 1'b0, "R4 R10 burst");
    send(8'd81, 8'd90, 8'd240, 1'b0, "R4 reddish");
    send(8'd145, 8'd54, 8'd34, 1'b0, "R4 greenish");
    drain();
  endtask

  task automatic t_saturate;
    send(8'd235, 8'd240, 8'd240, 1'b0, "R6 high clamp");
    send(8'd16, 8'd16, 8'd16, 1'b0, "R6 low clamp");
    send(8'd0, 8'd0, 8'd0, 1'b0, "R6 zero input");
    send(8'd255, 8'd255, 8'd255, 1'b0, "R6 full input");
    drain();
  endtask

  task automatic t_bypass;
    send(8'h12, 8'hfe, 8'h00, 1'b1, "R7 bypass");
    send(8'd16, 8'd128, 8'd128, 1'b0, "R7 mixed conv");
    send(8'hff, 8'h00, 8'h80, 1'b1, "R7 bypass 2");
    drain();
  endtask

  task automatic t_latency;
    int seen;
    seen = 0;
    send(8'd100, 8'd100, 8'd100, 1'b0, "R8 single");
    @(posedge clk);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid) seen = n;
    end
    // captured at edge n, visible after edge n+3: 4th negedge after capture
    check("R8 latency", 24'(seen), 24'd4);
  endtask

  task automatic t_map;
    wr(0, 14'h0000); wr(1, 14'h0400); wr(2, 14'h0000); wr(3, 14'h0010);  // G = U + 1
    wr(4, 14'h0000); wr(5, 14'h0000); wr(6, 14'h2400); wr(7, 14'h0000);  // R = V, bit13 ignored
    wr(8, 14'h0400); wr(9, 14'h0000); wr(10, 14'h0000); wr(11, 14'h3ff0); // B = Y - 1
    wr(13, 14'h3fff);  // no effect (R2)
    wr(12, 14'h1234);  // no effect (R2)
    send(8'd50, 8'd60, 8'd70, 1'b0, "R2 R3 map");
    send(8'd0, 8'd255, 8'd0, 1'b0, "R3 R6 const sign");
    idle(1);
    drain();
    check("R3 model map", {chan(1,50,60,70), chan(0,50,60,70), chan(2,50,60,70)}, {8'd70, 8'd61, 8'd49});
    check("R2 model hi addr", {chan(1,0,255,0), chan(0,0,255,0), chan(2,0,255,0)}, {8'd0, 8'd255, 8'd0});
  endtask

  task automatic t_deferred;
    logic [7:0] keep_r;
    // stream of 6; write R-row V weight to 0 during the 2nd pixel
    for (int i = 0; i < 6; i++) begin
      send(8'd120, 8'd128, 8'd200, 1'b0, "R9 old set in run");
      if (i == 1) begin
        cfg_we = 1'b1; cfg_addr = 4'd6; cfg_wdata = 14'h0000;
      end else begin
        cfg_we = 1'b0;
      end
    end
    keep_r = chan(1, 120, 128, 200);
    model_write(6, 14'h0000);
    idle(1);
    send(8'd120, 8'd128, 8'd200, 1'b0, "R9 new set after gap");
    check("R9 value changed", {7'd0, keep_r != chan(1, 120, 128, 200)}, 8'd1);
    drain();
  endtask

  initial begin
    for (int i = 0; i < 12; i++) bc[i] = 0;
    model_write(0, 14'h04a7); model_write(1, 14'h1e6f); model_write(2, 14'h1cbf); model_write(3, 14'h0877);
    model_write(4, 14'h04a7); model_write(5, 14'h0000); model_write(6, 14'h0662); model_write(7, 14'h3211);
    model_write(8, 14'h04a7); model_write(9, 14'h0812); model_write(10, 14'h0000); model_write(11, 14'h2eb1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_defaults();   // R1 defaults seen through R5 outputs
    t_burst();
    t_saturate();
    t_bypass();
    t_latency();
    t_map();
    load_defaults();
    t_deferred();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule